// File: doc/BRIEF.md
# Programmable Address Window Decoder

This block maps a 32-bit processor address onto one of thirteen programmable windows and reports which window won and which target it routes to. The windows come in three kinds. One window is fixed at 1 MB and serves the internal register space; only its base moves. Four windows serve the DRAM chip selects and are aligned to 16 MB. Eight general windows serve other resources and are aligned to 64 KB.

Each sizeable window holds a base, a size mask, a target code and an enable bit. All of them are programmed through a single-cycle write port that selects a window and a field. The decode is registered, so the result for an address appears one clock after the address. When several windows overlap, a fixed priority picks the winner. A size value that is not a run of ones starting at bit 0 is refused. The refusal sets a flag that stays set until reset.

Top module: `addr_window_map`

## Requirements
- R1: After reset, window 0 (register space, target 0xC) covers 0xD000_0000 to 0xD00F_FFFF. DRAM window i (index 1+i, target i) covers 256 MB at i×0x1000_0000 (base 0x10×i, mask 0x0F). Windows 0 to 4 are enabled. General window j (index 5+j, target 4+j) is disabled, with base 0 and mask 0.
- R2: Outputs `hit`, `win_idx` and `tgt` show the decode of the address present at the previous rising clock edge, one cycle of latency.
- R3: When no enabled window matches, `hit` is 0, `win_idx` is 0 and `tgt` is 0xF. During reset the outputs hold these same values, and `size_err` is 0.
- R4: DRAM window i hits when enabled and `(addr[31:24] ^ base) & ~mask` is zero. The base and mask are 8 bits, so the window spans (mask+1)×16 MB.
- R5: General window j hits when enabled and `(addr[31:16] ^ base) & ~mask` is zero. The base and mask are 16 bits, so the window spans (mask+1)×64 KB.
- R6: The register window compares a 12-bit base with `addr[31:20]` and is always exactly 1 MB. A size write aimed at it has no effect and raises no error.
- R7: A size value is legal when its ones run contiguously from bit 0, zero included. An illegal size write leaves the stored mask unchanged and sets `size_err`. `size_err` then stays 1 until reset. For DRAM windows only `wr_data[7:0]` counts.
- R8: Among windows that hit, the lowest index wins. Index 0 is the register window, indices 1 to 4 are the DRAM windows and indices 5 to 12 are the general windows.
- R9: While `wr_en` is 1, `wr_win` selects a window and `wr_field` selects what is written. Field 0 writes the base from the low bits of `wr_data`. Field 1 writes the size. Field 2 writes the target from `wr_data[3:0]`. Field 3 writes the enable from `wr_data[0]`. A write to a `wr_win` value of 13 to 15 changes nothing.
- R10: A write takes effect at the clock edge that samples it. An address decoded at that same edge still sees the old settings, and the next edge sees the new ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 32 | Address to decode |
| wr_en | input | 1 | Configuration write strobe |
| wr_win | input | 4 | Window index written |
| wr_field | input | 2 | Field written: 0 base, 1 size, 2 target, 3 enable |
| wr_data | input | 16 | Write value |
| hit | output | 1 | Registered: some enabled window matched |
| win_idx | output | 4 | Registered index of the winning window |
| tgt | output | 4 | Registered target code, 0xF on a miss |
| size_err | output | 1 | Sticky flag for a refused size write |

## Verification
A configuration write and a lookup can fall on the same clock edge. The rule is that the lookup still sees the old settings. To test this, the bench presents an address inside DRAM window 0 and, in the same cycle, writes that window's enable to 0. It expects a hit on index 1 one cycle later and a miss one cycle after that. The write strobe also coincides with lookups when an illegal size is refused. There the bench checks that the address lying inside the old mask still hits, which shows that the rejected value never reached the decode.

// File: rtl/awm_pkg.sv
package awm_pkg;

  localparam int ADDR_W = 32;
  localparam int DATA_W = 16;
  localparam int TGT_W  = 4;

  typedef logic [TGT_W-1:0] tgt_t;

  typedef enum logic [1:0] {
    FLD_BASE = 2'd0,
    FLD_SIZE = 2'd1,
    FLD_TGT  = 2'd2,
    FLD_EN   = 2'd3
  } fld_e;

  localparam tgt_t MISS_TGT = 4'hF;

  // A legal mask is a run of ones from bit 0 (zero included).
  function automatic logic size_ok(input logic [DATA_W-1:0] m);
    logic [DATA_W-1:0] inc;
    inc = m + 1'b1;
    return (m & inc) == '0;
  endfunction

  // Bits outside the mask must agree between address and base.
  function automatic logic in_window(input logic [DATA_W-1:0] a,
                                     input logic [DATA_W-1:0] b,
                                     input logic [DATA_W-1:0] m);
    return ((a ^ b) & ~m) == '0;
  endfunction

endpackage

// File: rtl/awm_win.sv
module awm_win
  import awm_pkg::*;
#(
  parameter int                BASE_W   = 8,
  parameter bit                HAS_MASK = 1'b1,
  parameter logic [BASE_W-1:0] RST_BASE = '0,
  parameter logic [BASE_W-1:0] RST_MASK = '0,
  parameter tgt_t              RST_TGT  = '0,
  parameter bit                RST_EN   = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BASE_W-1:0] addr_hi,
  input  logic              wr_sel,
  input  fld_e              wr_fld,
  input  logic [DATA_W-1:0] wr_data,
  output logic              match,
  output tgt_t              tgt,
  output logic              size_rej
);

  logic [BASE_W-1:0] base_q;
  logic [BASE_W-1:0] mask_q;
  logic [BASE_W-1:0] wr_val;
  tgt_t              tgt_q;
  logic              en_q;

  logic [DATA_W-1:0] a_ext, b_ext, m_ext, v_ext;
  logic              size_wr, size_legal;

  assign wr_val = wr_data[BASE_W-1:0];

  always_comb begin
    a_ext = '0;  a_ext[BASE_W-1:0] = addr_hi;
    b_ext = '0;  b_ext[BASE_W-1:0] = base_q;
    m_ext = '0;  m_ext[BASE_W-1:0] = mask_q;
    v_ext = '0;  v_ext[BASE_W-1:0] = wr_val;
  end

  assign size_wr    = wr_sel && (wr_fld == FLD_SIZE);
  assign size_legal = size_ok(v_ext);
  assign size_rej   = size_wr && HAS_MASK && !size_legal;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= RST_BASE;
      tgt_q  <= RST_TGT;
      en_q   <= RST_EN;
    end else if (wr_sel) begin
      case (wr_fld)
        FLD_BASE: base_q <= wr_val;
        FLD_TGT:  tgt_q  <= wr_data[TGT_W-1:0];
        FLD_EN:   en_q   <= wr_data[0];
        default:  ;
      endcase
    end
  end

  generate
    if (HAS_MASK) begin : g_mask
      always_ff @(posedge clk) begin
        if (!rst_n)                  mask_q <= RST_MASK;
        else if (size_wr && size_legal) mask_q <= wr_val;
      end
    end else begin : g_fixed
      assign mask_q = '0;
    end
  endgenerate

  assign match = en_q && in_window(a_ext, b_ext, m_ext);
  assign tgt   = tgt_q;

  // R7: the stored mask is always a legal run of ones
  assert_mask_legal_R7: assert property (@(posedge clk) disable iff (!rst_n)
    size_ok(m_ext));

  // R7: a refused size write leaves the mask untouched
  assert_reject_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
    size_rej |=> $stable(mask_q));

  // R9: an enable write lands on the next edge
  assert_enable_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sel && wr_fld == FLD_EN) |=> (en_q == $past(wr_data[0])));

endmodule

// File: rtl/awm_pick.sv
module awm_pick
  import awm_pkg::*;
#(
  parameter int N     = 13,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     req,
  input  tgt_t             tgt_in [N],
  output logic             any,
  output logic [IDX_W-1:0] idx,
  output tgt_t             tgt
);

  logic [N-1:0] gnt;

  // Scan from the top so the lowest requesting index is left standing.
  always_comb begin
    gnt = '0;
    idx = '0;
    tgt = MISS_TGT;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        gnt    = '0;
        gnt[i] = 1'b1;
        idx    = IDX_W'(i);
        tgt    = tgt_in[i];
      end
    end
  end

  assign any = |req;

  // R8: at most one grant, and only to a requester
  assert_one_grant_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt) && ((gnt & ~req) == '0));

  // R8: a request present means exactly one grant
  assert_grant_if_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req != '0) |-> ($countones(gnt) == 1));

endmodule

// File: rtl/addr_window_map.sv
module addr_window_map
  import awm_pkg::*;
#(
  parameter int   N_DRAM     = 4,
  parameter int   N_CFG      = 8,
  parameter int   DRAM_BW    = 8,
  parameter int   CFG_BW     = 16,
  parameter int   REG_BW     = 12,
  parameter int   DRAM_STEP  = 16,
  parameter logic [DRAM_BW-1:0] DRAM_RST_MASK = 8'h0F,
  parameter logic [REG_BW-1:0]  REG_RST_BASE  = 12'hD00,
  parameter tgt_t REG_TGT    = 4'hC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       addr,
  input  logic              wr_en,
  input  logic [3:0]        wr_win,
  input  logic [1:0]        wr_field,
  input  logic [15:0]       wr_data,
  output logic              hit,
  output logic [3:0]        win_idx,
  output logic [3:0]        tgt,
  output logic              size_err
);

  localparam int N_WIN   = 1 + N_DRAM + N_CFG;
  localparam int IDX_W   = $clog2(N_WIN);
  localparam int DRAM_LO = 1;
  localparam int CFG_LO  = 1 + N_DRAM;

  fld_e             wr_fld;
  logic [N_WIN-1:0] wr_sel;
  logic [N_WIN-1:0] win_hit;
  logic [N_WIN-1:0] win_rej;
  tgt_t             win_tgt [N_WIN];

  logic             pick_any;
  logic [IDX_W-1:0] pick_idx;
  tgt_t             pick_tgt;

  assign wr_fld = fld_e'(wr_field);

  always_comb begin
    for (int k = 0; k < N_WIN; k++)
      wr_sel[k] = wr_en && (wr_win == 4'(k));
  end

  // register-space window: fixed 1 MB, no mask
  awm_win #(
    .BASE_W(REG_BW), .HAS_MASK(1'b0), .RST_BASE(REG_RST_BASE),
    .RST_MASK('0), .RST_TGT(REG_TGT), .RST_EN(1'b1)
  ) u_reg_win (
    .clk(clk), .rst_n(rst_n), .addr_hi(addr[ADDR_W-1 -: REG_BW]),
    .wr_sel(wr_sel[0]), .wr_fld(wr_fld), .wr_data(wr_data),
    .match(win_hit[0]), .tgt(win_tgt[0]), .size_rej(win_rej[0])
  );

  generate
    for (genvar i = 0; i < N_DRAM; i++) begin : g_dram
      awm_win #(
        .BASE_W(DRAM_BW), .HAS_MASK(1'b1),
        .RST_BASE(DRAM_BW'(i * DRAM_STEP)), .RST_MASK(DRAM_RST_MASK),
        .RST_TGT(tgt_t'(i)), .RST_EN(1'b1)
      ) u_win (
        .clk(clk), .rst_n(rst_n), .addr_hi(addr[ADDR_W-1 -: DRAM_BW]),
        .wr_sel(wr_sel[DRAM_LO+i]), .wr_fld(wr_fld), .wr_data(wr_data),
        .match(win_hit[DRAM_LO+i]), .tgt(win_tgt[DRAM_LO+i]),
        .size_rej(win_rej[DRAM_LO+i])
      );
    end

    for (genvar j = 0; j < N_CFG; j++) begin : g_cfg
      awm_win #(
        .BASE_W(CFG_BW), .HAS_MASK(1'b1), .RST_BASE('0), .RST_MASK('0),
        .RST_TGT(tgt_t'(N_DRAM + j)), .RST_EN(1'b0)
      ) u_win (
        .clk(clk), .rst_n(rst_n), .addr_hi(addr[ADDR_W-1 -: CFG_BW]),
        .wr_sel(wr_sel[CFG_LO+j]), .wr_fld(wr_fld), .wr_data(wr_data),
        .match(win_hit[CFG_LO+j]), .tgt(win_tgt[CFG_LO+j]),
        .size_rej(win_rej[CFG_LO+j])
      );
    end
  endgenerate

  awm_pick #(.N(N_WIN), .IDX_W(IDX_W)) u_pick (
    .clk(clk), .rst_n(rst_n), .req(win_hit), .tgt_in(win_tgt),
    .any(pick_any), .idx(pick_idx), .tgt(pick_tgt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hit      <= 1'b0;
      win_idx  <= '0;
      tgt      <= MISS_TGT;
      size_err <= 1'b0;
    end else begin
      hit      <= pick_any;
      win_idx  <= 4'(pick_idx);
      tgt      <= pick_tgt;
      size_err <= size_err | (|win_rej);
    end
  end

  // R3: a miss carries index 0 and the miss target
  assert_miss_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> (tgt == MISS_TGT && win_idx == '0));

  // R8: a winning index names a real window
  assert_idx_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (win_idx < 4'(N_WIN)));

  // R7: the error flag never clears outside reset
  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    size_err |=> size_err);

  // R7: the error flag only rises after a size write
  assert_err_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(size_err) |-> $past(wr_en && wr_field == 2'd1));

endmodule

// File: tb/addr_window_map_test.sv
module addr_window_map_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] addr;
  logic        wr_en;
  logic [3:0]  wr_win;
  logic [1:0]  wr_field;
  logic [15:0] wr_data;
  logic        hit;
  logic [3:0]  win_idx;
  logic [3:0]  tgt;
  logic        size_err;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  addr_window_map uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_win(wr_win),
    .wr_field(wr_field), .wr_data(wr_data), .hit(hit), .win_idx(win_idx),
    .tgt(tgt), .size_err(size_err)
  );

  // {addr, hit, idx, tgt} against the reset map
  localparam logic [40:0] VEC [10] = '{
    {32'h0000_0000, 1'b1, 4'd1, 4'h0},  // R1 R4 dram0
    {32'h1234_5678, 1'b1, 4'd2, 4'h1},  // R1 R4 dram1
    {32'h2FFF_FFFF, 1'b1, 4'd3, 4'h2},  // R1 R4 dram2 top
    {32'h3800_0000, 1'b1, 4'd4, 4'h3},  // R1 R4 dram3
    {32'h4000_0000, 1'b0, 4'd0, 4'hF},  // R3 gap
    {32'hD000_0000, 1'b1, 4'd0, 4'hC},  // R1 R6 reg low
    {32'hD00F_FFFF, 1'b1, 4'd0, 4'hC},  // R6 reg top
    {32'hD010_0000, 1'b0, 4'd0, 4'hF},  // R6 just past 1 MB
    {32'h9000_0000, 1'b0, 4'd0, 4'hF},  // R1 general windows off
    {32'hFFFF_FFFF, 1'b0, 4'd0, 4'hF}   // R3
  };

  task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string tag);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic chk_out(input logic eh, input logic [3:0] ei, input logic [3:0] et,
                         input string tag);
    chk({23'd0, hit, win_idx, tgt}, {23'd0, eh, ei, et}, tag);
  endtask

  task automatic look(input logic [31:0] a, input logic eh, input logic [3:0] ei,
                      input logic [3:0] et, input string tag);
    @(negedge clk);
    addr = a;
    @(negedge clk);
    chk_out(eh, ei, et, tag);
  endtask

  task automatic cfg_wr(input logic [3:0] w, input logic [1:0] f, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_win = w; wr_field = f; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; addr = '0; wr_en = 1'b0; wr_win = '0; wr_field = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    chk_out(1'b0, 4'd0, 4'hF, "R3 outputs in reset");
    chk({31'd0, size_err}, 32'd0, "R3 size_err in reset");
    rst_n = 1'b1;

    for (int v = 0; v < 10; v++)
      look(VEC[v][40:9], VEC[v][8], VEC[v][7:4], VEC[v][3:0], $sformatf("R1 map vector %0d", v));

    // R2: back-to-back addresses, each result one cycle later
    @(negedge clk); addr = 32'h2000_0000;
    @(negedge clk); addr = 32'hD000_0000;
    chk_out(1'b1, 4'd3, 4'h2, "R2 first of pair");
    @(negedge clk);
    chk_out(1'b1, 4'd0, 4'hC, "R2 second of pair");

    // R5: general window 0 at 0x9000_0000, 128 MB, target 7
    cfg_wr(4'd5, 2'd0, 16'h9000);
    cfg_wr(4'd5, 2'd1, 16'h07FF);
    cfg_wr(4'd5, 2'd2, 16'h0007);
    cfg_wr(4'd5, 2'd3, 16'h0001);
    look(32'h97FF_FFFF, 1'b1, 4'd5, 4'h7, "R5 top of 128 MB");
    look(32'h9800_0000, 1'b0, 4'd0, 4'hF, "R5 past 128 MB");

    // R8: general window 7, 64 KB inside window 5
    cfg_wr(4'd12, 2'd0, 16'h9000);
    cfg_wr(4'd12, 2'd2, 16'h000A);
    cfg_wr(4'd12, 2'd3, 16'h0001);
    look(32'h9000_1234, 1'b1, 4'd5, 4'h7, "R8 lower general index wins");
    cfg_wr(4'd5, 2'd3, 16'h0000);
    look(32'h9000_1234, 1'b1, 4'd12, 4'hA, "R5 64 KB window alone");
    look(32'h9001_0000, 1'b0, 4'd0, 4'hF, "R5 past 64 KB");

    // R8: whole-space general window 1 against register window
    cfg_wr(4'd6, 2'd1, 16'hFFFF);
    cfg_wr(4'd6, 2'd3, 16'h0001);
    look(32'hD000_0000, 1'b1, 4'd0, 4'hC, "R8 register window first");
    look(32'h5000_0000, 1'b1, 4'd6, 4'h5, "R1 reset target of general 1");
    look(32'h1000_0000, 1'b1, 4'd2, 4'h1, "R8 DRAM before general");
    cfg_wr(4'd6, 2'd3, 16'h0000);

    // R6: register window moved, size write ignored
    cfg_wr(4'd0, 2'd0, 16'h0F10);
    look(32'hF10A_BCDE, 1'b1, 4'd0, 4'hC, "R6 moved base");
    look(32'hD000_0000, 1'b0, 4'd0, 4'hF, "R6 old base gone");
    cfg_wr(4'd0, 2'd1, 16'h0FFF);
    look(32'hF110_0000, 1'b0, 4'd0, 4'hF, "R6 size write ignored");
    chk({31'd0, size_err}, 32'd0, "R6 no error on register size write");

    // R4: DRAM 3 at 0x4000_0000, 1 GB
    cfg_wr(4'd4, 2'd0, 16'h0040);
    cfg_wr(4'd4, 2'd1, 16'h003F);
    look(32'h7FFF_FFFF, 1'b1, 4'd4, 4'h3, "R4 1 GB top");
    look(32'h8000_0000, 1'b0, 4'd0, 4'hF, "R4 past 1 GB");

    // R7: illegal sizes refused
    cfg_wr(4'd4, 2'd1, 16'h0005);
    chk({31'd0, size_err}, 32'd1, "R7 error set");
    look(32'h7FFF_FFFF, 1'b1, 4'd4, 4'h3, "R7 DRAM mask kept");
    cfg_wr(4'd12, 2'd1, 16'h0100);
    look(32'h9001_0000, 1'b0, 4'd0, 4'hF, "R7 general mask kept");
    chk({31'd0, size_err}, 32'd1, "R7 error sticky");
    cfg_wr(4'd4, 2'd1, 16'h0000);
    look(32'h40FF_FFFF, 1'b1, 4'd4, 4'h3, "R7 zero mask 16 MB");
    look(32'h4100_0000, 1'b0, 4'd0, 4'hF, "R7 zero mask edge");

    // R9: nonexistent window index, then a target write
    cfg_wr(4'd13, 2'd0, 16'h00FF);
    cfg_wr(4'd15, 2'd3, 16'h0000);
    look(32'h0000_0000, 1'b1, 4'd1, 4'h0, "R9 index 13-15 ignored");
    cfg_wr(4'd1, 2'd2, 16'h0009);
    look(32'h0000_0000, 1'b1, 4'd1, 4'h9, "R9 target write");

    // R10: lookup and disable on the same edge
    @(negedge clk);
    addr = 32'h0100_0000;
    wr_en = 1'b1; wr_win = 4'd1; wr_field = 2'd3; wr_data = 16'h0000;
    @(negedge clk);
    wr_en = 1'b0;
    chk_out(1'b1, 4'd1, 4'h9, "R10 same edge sees old");
    @(negedge clk);
    chk_out(1'b0, 4'd0, 4'hF, "R10 next edge sees new");

    // R1: reset restores the default map
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    chk({31'd0, size_err}, 32'd0, "R1 error cleared by reset");
    look(32'h0000_0000, 1'b1, 4'd1, 4'h0, "R1 DRAM0 restored");
    look(32'hD000_0000, 1'b1, 4'd0, 4'hC, "R1 register window restored");
    look(32'h9000_1234, 1'b0, 4'd0, 4'hF, "R1 general windows disabled");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule